// File: doc/BRIEF.md
# Hardware Stack with Indexed Peek and Call Linkage

This block is a synchronous last-in-first-out store of 16-bit words for a small pipelined processor. It accepts at most one operation per clock: push a word, pop the top word, or peek at any depth below the top without disturbing the stack. Depth 0 is the top entry. The peek depth comes either from a 10-bit immediate or from a 16-bit register operand, chosen by the instruction format.

The same storage holds 12-bit return addresses. A call stores the supplied return address (the caller's PC plus one) as an ordinary entry. A return removes the top entry and presents its low 12 bits as the next PC.

A push or call onto a full stack raises overflow and changes nothing. A pop, return or peek that reaches past the stored entries raises underflow and yields zero. Every result and flag is registered. It appears in the cycle after the clock edge that accepted the operation and lasts one cycle.

Top module: `stack_unit`

## Requirements
- R1: A synchronous active-high reset empties the stack and clears every output to 0. A pop issued right after reset reports underflow.
- R2: opCode 0011 with funct 10 stores pushData on top. opCode 0011 with funct 00 removes the top entry and returns it on rdData with rdValid high. Entries come back in reverse order of storage, and each result appears the cycle after the accepting edge.
- R3: opCode 0011 with funct 01 returns the entry at the given depth (0 = top) on rdData with rdValid high. It leaves the occupancy and contents unchanged.
- R4: The peek depth is immDepth (zero-extended) when fmtSel is 01, and regDepth for any other fmtSel value.
- R5: opCode 0110 (call) stores retAddr, zero-extended, as a new top entry. opCode 0111 (return) removes the top entry and drives its low 12 bits on retTarget with retValid high.
- R6: A push onto a stack holding DEPTH (256) entries pulses overflow for one cycle and leaves the contents and occupancy unchanged.
- R7: A pop or return on an empty stack, or a peek whose depth is not below the occupancy, pulses underflow. The pop or peek result is 0 with rdValid high; the return result is 0 with retValid high. The stack is unchanged.
- R8: When valid is low, or when opCode 0011 comes with funct 11, or with any opCode other than 0011, 0110 or 0111, the operation has no effect and all result strobes stay low.
- R9: A call onto a full stack pulses overflow and stores nothing. The entry already on top is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Operation present this cycle |
| fmtSel | input | 2 | Instruction format; 01 selects immediate depth |
| opCode | input | 4 | Major opcode |
| funct | input | 2 | Stack sub-operation |
| immDepth | input | 10 | Immediate peek depth |
| regDepth | input | 16 | Register peek depth |
| pushData | input | 16 | Word to push |
| retAddr | input | 12 | Return address stored by a call |
| rdData | output | 16 | Pop or peek result |
| rdValid | output | 1 | rdData holds a result this cycle |
| retTarget | output | 12 | Next PC after a return |
| retValid | output | 1 | retTarget holds a result this cycle |
| overflow | output | 1 | Last operation hit a full stack |
| underflow | output | 1 | Last operation reached past the stored entries |

## Verification
Every result strobe, data word and flag is due exactly one cycle after the edge that accepted the operation. Nothing is due for a dropped operation, so all strobes read low in that slot. The driver applies one operation per cycle at the falling edge and queues, from a queue-based stack model, what that operation must produce in the next slot. The monitor wakes 5 ns after each rising edge and compares every output with the oldest queued entry, so each slot is checked against its own operation and never against a neighbour's.

// File: rtl/stack_pkg.sv
package stack_pkg;

  localparam logic [3:0] OP_STACK = 4'b0011;
  localparam logic [3:0] OP_CALL  = 4'b0110;
  localparam logic [3:0] OP_RET   = 4'b0111;

  localparam logic [1:0] FN_POP   = 2'b00;
  localparam logic [1:0] FN_PEEK  = 2'b01;
  localparam logic [1:0] FN_PUSH  = 2'b10;

  localparam logic [1:0] FMT_IMM  = 2'b01;

  // Strobes from control to datapath
  typedef struct packed {
    logic wr;       // write an entry at wrIdx
    logic link;     // written entry is a return address
    logic dataOut;  // report a pop/peek result
    logic retOut;   // report a return target
    logic hit;      // rdIdx addresses a live entry
    logic ovf;
    logic unf;
  } stackStrobe_t;

endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 10,
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [1:0]        fmtSel,
  input  logic [3:0]        opCode,
  input  logic [1:0]        funct,
  input  logic [IMM_W-1:0]  immDepth,
  input  logic [DATA_W-1:0] regDepth,
  output stackStrobe_t      strb,
  output logic [PTR_W-1:0]  wrIdx,
  output logic [PTR_W-1:0]  rdIdx
);

  localparam int CMP_W = (DATA_W > CNT_W) ? DATA_W : CNT_W;

  logic [CNT_W-1:0]  count, countNext, topIdx, peekIdx;
  logic [DATA_W-1:0] depth;
  logic              isEmpty, isFull, depthOk;

  assign depth   = (fmtSel == FMT_IMM) ? DATA_W'(immDepth) : regDepth;
  assign isEmpty = (count == '0);
  assign isFull  = (count == CNT_W'(DEPTH));
  assign topIdx  = count - CNT_W'(1);
  assign peekIdx = topIdx - depth[CNT_W-1:0];
  assign depthOk = CMP_W'(depth) < CMP_W'(count);

  always_comb begin
    strb      = '0;
    countNext = count;
    wrIdx     = count[PTR_W-1:0];
    rdIdx     = topIdx[PTR_W-1:0];
    if (valid) begin
      unique case (opCode)
        OP_STACK: begin
          unique case (funct)
            FN_POP: begin
              strb.dataOut = 1'b1;
              if (isEmpty) strb.unf = 1'b1;
              else begin
                strb.hit  = 1'b1;
                countNext = topIdx;
              end
            end
            FN_PEEK: begin
              strb.dataOut = 1'b1;
              if (depthOk) begin
                strb.hit = 1'b1;
                rdIdx    = peekIdx[PTR_W-1:0];
              end else strb.unf = 1'b1;
            end
            FN_PUSH: begin
              if (isFull) strb.ovf = 1'b1;
              else begin
                strb.wr   = 1'b1;
                countNext = count + CNT_W'(1);
              end
            end
            default: ;
          endcase
        end
        OP_CALL: begin
          if (isFull) strb.ovf = 1'b1;
          else begin
            strb.wr   = 1'b1;
            strb.link = 1'b1;
            countNext = count + CNT_W'(1);
          end
        end
        OP_RET: begin
          strb.retOut = 1'b1;
          if (isEmpty) strb.unf = 1'b1;
          else begin
            strb.hit  = 1'b1;
            countNext = topIdx;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= countNext;
  end

  // R6
  no_count_over_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R6
  no_overflow_move_chk: assert property (@(posedge clk) disable iff (rst)
    strb.ovf |=> $stable(count));

  // R3
  no_peek_move_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && opCode == OP_STACK && funct == FN_PEEK) |=> $stable(count));

  // R7
  no_underflow_move_chk: assert property (@(posedge clk) disable iff (rst)
    strb.unf |=> $stable(count));

endmodule

// File: rtl/stack_dp.sv
module stack_dp
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 12,
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  stackStrobe_t      strb,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] pushData,
  input  logic [PC_W-1:0]   retAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [PC_W-1:0]   retTarget,
  output logic              retValid,
  output logic              overflow,
  output logic              underflow
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] entry;

  assign entry = strb.hit ? store[rdIdx] : '0;

  always_ff @(posedge clk) begin
    if (strb.wr) store[wrIdx] <= strb.link ? DATA_W'(retAddr) : pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      retTarget <= '0;
      retValid  <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      rdValid   <= strb.dataOut;
      rdData    <= strb.dataOut ? entry : '0;
      retValid  <= strb.retOut;
      retTarget <= strb.retOut ? entry[PC_W-1:0] : '0;
      overflow  <= strb.ovf;
      underflow <= strb.unf;
    end
  end

  // R7
  no_underflow_data_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (rdData == '0 && retTarget == '0));

  // R8
  no_dual_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rdValid, retValid, overflow}));

  // R7
  no_flag_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(overflow && underflow));

endmodule

// File: rtl/stack_unit.sv
module stack_unit
  import stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 12,
  parameter int IMM_W  = 10,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [1:0]        fmtSel,
  input  logic [3:0]        opCode,
  input  logic [1:0]        funct,
  input  logic [IMM_W-1:0]  immDepth,
  input  logic [DATA_W-1:0] regDepth,
  input  logic [DATA_W-1:0] pushData,
  input  logic [PC_W-1:0]   retAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [PC_W-1:0]   retTarget,
  output logic              retValid,
  output logic              overflow,
  output logic              underflow
);

  localparam int PTR_W = $clog2(DEPTH);

  stackStrobe_t     strb;
  logic [PTR_W-1:0] wrIdx, rdIdx;

  stack_ctrl #(.DATA_W(DATA_W), .IMM_W(IMM_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .valid(valid), .fmtSel(fmtSel), .opCode(opCode),
    .funct(funct), .immDepth(immDepth), .regDepth(regDepth),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  stack_dp #(.DATA_W(DATA_W), .PC_W(PC_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .pushData(pushData), .retAddr(retAddr),
    .rdData(rdData), .rdValid(rdValid), .retTarget(retTarget),
    .retValid(retValid), .overflow(overflow), .underflow(underflow)
  );

endmodule

// File: tb/tb_stack_unit.sv
module tb_stack_unit;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [1:0]  fmtSel = 2'b00;
  logic [3:0]  opCode = 4'h0;
  logic [1:0]  funct = 2'b00;
  logic [9:0]  immDepth = '0;
  logic [15:0] regDepth = '0;
  logic [15:0] pushData = '0;
  logic [11:0] retAddr = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic [11:0] retTarget;
  logic        retValid;
  logic        overflow;
  logic        underflow;

  stack_unit dut (
    .clk(clk), .rst(rst), .valid(valid), .fmtSel(fmtSel), .opCode(opCode),
    .funct(funct), .immDepth(immDepth), .regDepth(regDepth),
    .pushData(pushData), .retAddr(retAddr), .rdData(rdData),
    .rdValid(rdValid), .retTarget(retTarget), .retValid(retValid),
    .overflow(overflow), .underflow(underflow)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic        rv;
    logic [15:0] rd;
    logic        tv;
    logic [11:0] tg;
    logic        ov;
    logic        un;
    string       req;
  } expect_t;

  expect_t     sb[$];
  int unsigned model[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  // Monitor: one slot per cycle, sampled 5 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        expect_t e;
        e = sb.pop_front();
        checks++;
        if (rdValid !== e.rv || rdData !== e.rd || retValid !== e.tv ||
            retTarget !== e.tg || overflow !== e.ov || underflow !== e.un) begin
          errors++;
          $display("FAIL %s: got rv=%0b rd=%h tv=%0b tg=%h ov=%0b un=%0b expected rv=%0b rd=%h tv=%0b tg=%h ov=%0b un=%0b",
                   e.req, rdValid, rdData, retValid, retTarget, overflow, underflow,
                   e.rv, e.rd, e.tv, e.tg, e.ov, e.un);
        end
      end
    end
  end

  // Driver: applies one operation at the falling edge and queues its result
  task automatic drive(input bit v, input logic [1:0] f, input logic [3:0] op,
                       input logic [1:0] fn, input logic [9:0] imm,
                       input logic [15:0] reg_d, input logic [15:0] data,
                       input logic [11:0] ra, input string req);
    expect_t e;
    int unsigned d;
    @(negedge clk);
    valid = v; fmtSel = f; opCode = op; funct = fn; immDepth = imm;
    regDepth = reg_d; pushData = data; retAddr = ra;
    e = '{rv: 1'b0, rd: 16'h0, tv: 1'b0, tg: 12'h0, ov: 1'b0, un: 1'b0, req: req};
    if (v && op == 4'b0011) begin
      if (fn == 2'b00) begin
        e.rv = 1'b1;
        if (model.size() == 0) e.un = 1'b1;
        else e.rd = 16'(model.pop_back());
      end else if (fn == 2'b01) begin
        e.rv = 1'b1;
        d = (f == 2'b01) ? 32'(imm) : 32'(reg_d);
        if (d < model.size()) e.rd = 16'(model[model.size() - 1 - d]);
        else e.un = 1'b1;
      end else if (fn == 2'b10) begin
        if (model.size() == DEPTH) e.ov = 1'b1;
        else model.push_back(32'(data));
      end
    end else if (v && op == 4'b0110) begin
      if (model.size() == DEPTH) e.ov = 1'b1;
      else model.push_back(32'(ra));
    end else if (v && op == 4'b0111) begin
      e.tv = 1'b1;
      if (model.size() == 0) e.un = 1'b1;
      else e.tg = 12'(model.pop_back());
    end
    sb.push_back(e);
  endtask

  task automatic push(input logic [15:0] x, input string req);
    drive(1, 2'b00, 4'b0011, 2'b10, '0, '0, x, '0, req);
  endtask
  task automatic pop(input string req);
    drive(1, 2'b00, 4'b0011, 2'b00, '0, '0, '0, '0, req);
  endtask
  task automatic peekImm(input logic [9:0] d, input string req);
    drive(1, 2'b01, 4'b0011, 2'b01, d, 16'hFFFF, '0, '0, req);
  endtask
  task automatic peekReg(input logic [15:0] d, input string req);
    drive(1, 2'b00, 4'b0011, 2'b01, 10'h3FF, d, '0, '0, req);
  endtask
  task automatic call(input logic [11:0] a, input string req);
    drive(1, 2'b10, 4'b0110, 2'b00, '0, '0, 16'hBEEF, a, req);
  endtask
  task automatic ret(input string req);
    drive(1, 2'b00, 4'b0111, 2'b00, '0, '0, '0, '0, req);
  endtask
  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) drive(0, 2'b00, 4'b0000, 2'b00, '0, '0, '0, '0, req);
  endtask

  task automatic doReset();
    idle(2, "R8");
    @(negedge clk);
    valid = 1'b0;
    rst = 1'b1;
    model.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rdValid !== 1'b0 || rdData !== 16'h0 || retValid !== 1'b0 ||
        retTarget !== 12'h0 || overflow !== 1'b0 || underflow !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs after reset rv=%0b rd=%h tv=%0b tg=%h ov=%0b un=%0b expected all 0",
               rdValid, rdData, retValid, retTarget, overflow, underflow);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rdValid !== 1'b0 || rdData !== 16'h0 || retValid !== 1'b0 ||
        overflow !== 1'b0 || underflow !== 1'b0) begin
      errors++;
      $display("FAIL R1: initial outputs rv=%0b rd=%h ov=%0b un=%0b expected 0",
               rdValid, rdData, overflow, underflow);
    end

    pop("R1");
    ret("R7");
    peekImm(10'd0, "R7");

    for (int i = 0; i < 6; i++) push(16'hA000 + 16'(i * 17), "R2");
    for (int i = 0; i < 6; i++) peekImm(10'(i), "R3");
    peekImm(10'd6, "R7");
    peekReg(16'd2, "R4");
    peekReg(16'd5, "R4");
    peekReg(16'd6, "R7");
    peekReg(16'h8001, "R7");
    drive(1, 2'b11, 4'b0011, 2'b01, 10'd0, 16'd4, '0, '0, "R4");

    drive(0, 2'b00, 4'b0011, 2'b10, '0, '0, 16'h1111, '0, "R8");
    drive(1, 2'b00, 4'b0011, 2'b11, '0, '0, 16'h2222, '0, "R8");
    drive(1, 2'b00, 4'b0101, 2'b10, '0, '0, 16'h3333, '0, "R8");
    peekImm(10'd0, "R8");

    pop("R2");
    pop("R2");
    push(16'h5A5A, "R2");
    pop("R2");

    call(12'h123, "R5");
    push(16'h7777, "R5");
    peekImm(10'd1, "R5");
    pop("R5");
    ret("R5");
    call(12'hFFF, "R5");
    ret("R5");
    ret("R5");

    while (model.size() < DEPTH) push(16'(model.size() * 3 + 1), "R6");
    push(16'hDEAD, "R6");
    call(12'h456, "R9");
    peekImm(10'd255, "R3");
    peekImm(10'd256, "R7");
    peekReg(16'd128, "R3");
    pop("R6");
    call(12'h456, "R9");
    ret("R9");
    for (int i = 0; i < 20; i++) pop("R2");

    doReset();
    pop("R1");
    ret("R1");
    idle(3, "R8");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule